// File: doc/BRIEF.md
# Banked Host Window to Video Memory Address Decoder

This block sits between a host memory bus and a video memory controller. For each host memory cycle it decides whether the address belongs to the display adapter. If it does, it produces the matching video memory address. There are two routes to a hit:

- **Legacy window.** One of four host windows is enabled. The offset into that window is added to a bank base, and the sum wraps within the installed video memory.
- **Linear aperture.** Video memory is mapped as one flat block in a power-of-two slot above the legacy area, at a programmable base.

The block keeps two bank registers. When dual-bank operation is enabled, reads use the first and writes use the second. A single copy loop inside the window can then move data between two unrelated regions of video memory. The bank step is chosen at run time.

A small classifier state machine registers the outcome of each cycle. Its states are:

- ST_MISS: no cycle, or no match.
- ST_WIN: window match.
- ST_LIN: aperture match.

On every clock edge the next state is taken from the decode of the presented cycle:

- A valid cycle that falls in the enabled window goes to ST_WIN.
- Otherwise, a valid cycle that falls in the enabled aperture goes to ST_LIN.
- Anything else goes to ST_MISS.

Any state can reach any other state in one edge.

Top module: `vwin_decoder`

## Requirements
- R1: After reset the outputs are vm_hit=0 and vm_addr=0. The configuration after reset is window off, aperture off, both banks 0, 4K step and dual-bank off.
- R2: Window mode code 1 (graphics) covers host addresses 0xA0000 to 0xAFFFF. The window offset is the host address minus 0xA0000.
- R3: Mode code 2 covers 0xB0000 to 0xB7FFF, and mode code 3 covers 0xB8000 to 0xBFFFF. Each has a 32K offset measured from its own base. Addresses outside the selected range do not hit.
- R4: Mode code 4 (combined) covers 0xA0000 to 0xBFFFF, giving offsets 0 to 0x1FFFF.
- R5: The window video address is (bank shifted left by S) + offset, taken modulo 2^MEM_AW (1MB by default). S is 12, 14, 15 or 16 for step codes 0, 1, 2 and 3 respectively.
- R6: With dual-bank off, bank A is used for both reads and writes. With dual-bank on, reads use bank A and writes use bank B.
- R7: With the aperture enabled, a valid cycle hits the aperture when host_addr[ADDR_W-1:MEM_AW] equals the aperture base. In that case vm_addr = host_addr[MEM_AW-1:0].
- R8: When a host address matches both the window and the aperture, the window decode wins.
- R9: vm_hit is 0 in three cases: when no valid cycle was presented, when the window mode is 0 or 5–7 and the aperture is off, and when the address matches neither the window nor the aperture.
- R10: Results appear on vm_hit and vm_addr one clock after the cycle is presented. A configuration write is used by cycles presented after its clock edge. The cfg_sel encoding is: 0 = control, 1 = bank A, 2 = bank B, 3 = aperture base. The control fields are: mode in bits [2:0], step in bits [4:3], dual-bank in bit 5, aperture enable in bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host memory cycle present |
| host_write | input | 1 | 1 = write cycle, 0 = read cycle |
| host_addr | input | ADDR_W (24) | Host byte address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 bank A, 2 bank B, 3 aperture base |
| cfg_wdata | input | BANK_W (8) | Configuration write data |
| vm_hit | output | 1 | Registered: previous cycle decoded to video memory |
| vm_addr | output | MEM_AW (20) | Registered video memory address, 0 on a miss |

## Verification
A corrupted bank or step register shows up as a wrong vm_addr on the first window cycle presented after the corruption. The error is an offset by a multiple of the step size, which the bench catches by comparing against a sum it computes itself. If the classifier is stuck in the wrong state, vm_hit is wrong one clock after the offending cycle. Each check therefore samples at that single registered stage. A swapped read/write bank choice appears only when dual-bank is on, and a write and a read to the same host address separate it immediately.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

    typedef enum logic [2:0] {
        WM_OFF   = 3'd0,
        WM_GFX   = 3'd1,
        WM_MONO  = 3'd2,
        WM_COLOR = 3'd3,
        WM_WIDE  = 3'd4
    } win_mode_e;

    typedef enum logic [1:0] {
        ST_MISS = 2'd0,
        ST_WIN  = 2'd1,
        ST_LIN  = 2'd2
    } cls_state_e;

    typedef struct packed {
        logic       ap_en;
        logic       dual;
        logic [1:0] step;
        logic [2:0] mode;
    } ctrl_t;

    localparam int OFF_W = 17;

endpackage

// File: rtl/vwin_cfg.sv
module vwin_cfg
    import vwin_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int AP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BANK_W-1:0] cfg_wdata,
    output ctrl_t             ctrl,
    output logic [BANK_W-1:0] bank_a,
    output logic [BANK_W-1:0] bank_b,
    output logic [AP_W-1:0]   ap_base
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            bank_a  <= '0;
            bank_b  <= '0;
            ap_base <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                2'd0: ctrl    <= ctrl_t'(cfg_wdata[6:0]);
                2'd1: bank_a  <= cfg_wdata;
                2'd2: bank_b  <= cfg_wdata;
                2'd3: ap_base <= cfg_wdata[AP_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vwin_window.sv
module vwin_window
    import vwin_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] haddr,
    output logic              win_in,
    output logic [OFF_W-1:0]  win_off
);

    localparam logic [ADDR_W-1:0] A_GFX_LO = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] A_GFX_HI = ADDR_W'(32'h000A_FFFF);
    localparam logic [ADDR_W-1:0] A_MON_LO = ADDR_W'(32'h000B_0000);
    localparam logic [ADDR_W-1:0] A_MON_HI = ADDR_W'(32'h000B_7FFF);
    localparam logic [ADDR_W-1:0] A_COL_LO = ADDR_W'(32'h000B_8000);
    localparam logic [ADDR_W-1:0] A_COL_HI = ADDR_W'(32'h000B_FFFF);

    logic [ADDR_W-1:0] lo, hi;
    logic [OFF_W-1:0]  base_low;
    logic              en;

    always_comb begin
        en       = 1'b1;
        lo       = A_GFX_LO;
        hi       = A_GFX_HI;
        base_low = '0;
        unique case (mode)
            WM_GFX:   begin lo = A_GFX_LO; hi = A_GFX_HI; base_low = 17'h00000; end
            WM_MONO:  begin lo = A_MON_LO; hi = A_MON_HI; base_low = 17'h10000; end
            WM_COLOR: begin lo = A_COL_LO; hi = A_COL_HI; base_low = 17'h18000; end
            WM_WIDE:  begin lo = A_GFX_LO; hi = A_COL_HI; base_low = 17'h00000; end
            default:  en = 1'b0;
        endcase
        win_in  = en && (haddr >= lo) && (haddr <= hi);
        win_off = haddr[OFF_W-1:0] - base_low;
    end

endmodule

// File: rtl/vwin_bank_map.sv
module vwin_bank_map
    import vwin_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int MEM_AW = 20
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [1:0]        step,
    input  logic [OFF_W-1:0]  offset,
    output logic [MEM_AW-1:0] vaddr
);

    localparam int SC_W = BANK_W + 16;

    logic [SC_W-1:0] scaled;

    always_comb begin
        unique case (step)
            2'd0: scaled = SC_W'(bank) << 12;
            2'd1: scaled = SC_W'(bank) << 14;
            2'd2: scaled = SC_W'(bank) << 15;
            default: scaled = SC_W'(bank) << 16;
        endcase
        vaddr = scaled[MEM_AW-1:0] + MEM_AW'(offset);
    end

    wire unused_scaled_hi = ^scaled[SC_W-1:MEM_AW];

endmodule

// File: rtl/vwin_decoder.sv
module vwin_decoder
    import vwin_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 20,
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BANK_W-1:0] cfg_wdata,
    output logic              vm_hit,
    output logic [MEM_AW-1:0] vm_addr
);

    localparam int AP_W = ADDR_W - MEM_AW;

    ctrl_t             ctrl;
    logic [BANK_W-1:0] bank_a, bank_b, bank_sel;
    logic [AP_W-1:0]   ap_base;
    logic              ap_en;
    logic              win_in, lin_in;
    logic [OFF_W-1:0]  win_off;
    logic [MEM_AW-1:0] win_vaddr;

    cls_state_e        state, state_nx;
    logic [MEM_AW-1:0] addr_q, addr_nx;

    vwin_cfg #(.BANK_W(BANK_W), .AP_W(AP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl(ctrl), .bank_a(bank_a),
        .bank_b(bank_b), .ap_base(ap_base)
    );

    vwin_window #(.ADDR_W(ADDR_W)) u_win (
        .mode(ctrl.mode), .haddr(host_addr),
        .win_in(win_in), .win_off(win_off)
    );

    assign bank_sel = (ctrl.dual && host_write) ? bank_b : bank_a;

    vwin_bank_map #(.BANK_W(BANK_W), .MEM_AW(MEM_AW)) u_map (
        .bank(bank_sel), .step(ctrl.step),
        .offset(win_off), .vaddr(win_vaddr)
    );

    assign ap_en  = ctrl.ap_en;
    assign lin_in = ap_en && (host_addr[ADDR_W-1:MEM_AW] == ap_base);

    // next-state decode
    always_comb begin
        state_nx = ST_MISS;
        addr_nx  = '0;
        if (host_valid && win_in) begin
            state_nx = ST_WIN;
            addr_nx  = win_vaddr;
        end else if (host_valid && lin_in) begin
            state_nx = ST_LIN;
            addr_nx  = host_addr[MEM_AW-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_MISS;
            addr_q <= '0;
        end else begin
            state  <= state_nx;
            addr_q <= addr_nx;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_WIN, ST_LIN: begin vm_hit = 1'b1; vm_addr = addr_q; end
            default:        begin vm_hit = 1'b0; vm_addr = '0;     end
        endcase
    end

endmodule

// File: rtl/vwin_decoder_chk.sv
module vwin_decoder_chk #(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic [ADDR_W-1:0] host_addr,
    input logic              vm_hit,
    input logic [MEM_AW-1:0] vm_addr,
    input logic              ap_en,
    input logic [ADDR_W-MEM_AW-1:0] ap_base,
    input logic              win_in
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !vm_hit);

    assert_idle_nohit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> !vm_hit);

    assert_nomatch_nohit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !win_in && !(ap_en && host_addr[ADDR_W-1:MEM_AW] == ap_base))
        |=> !vm_hit);

    assert_aperture_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !win_in && ap_en && host_addr[ADDR_W-1:MEM_AW] == ap_base)
        |=> (vm_hit && vm_addr == $past(host_addr[MEM_AW-1:0])));

    assert_window_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && win_in) |=> vm_hit);

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vm_hit |-> (vm_addr == '0));

endmodule

bind vwin_decoder vwin_decoder_chk #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
    .vm_hit(vm_hit), .vm_addr(vm_addr), .ap_en(ap_en), .ap_base(ap_base),
    .win_in(win_in)
);

// File: tb/tb_vwin_decoder.sv
`timescale 1ns/1ps
module tb_vwin_decoder;

    localparam int ADDR_W = 24;
    localparam int MEM_AW = 20;
    localparam int BANK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_valid = 1'b0;
    logic              host_write = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [BANK_W-1:0] cfg_wdata = '0;
    logic              vm_hit;
    logic [MEM_AW-1:0] vm_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vwin_decoder #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .BANK_W(BANK_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vm_hit(vm_hit), .vm_addr(vm_addr)
    );

    function automatic logic [MEM_AW-1:0] expect_addr(input int bank, input int step, input int off);
        int sh;
        longint full;
        sh = (step == 0) ? 12 : (step == 1) ? 14 : (step == 2) ? 15 : 16;
        full = (longint'(bank) << sh) + longint'(off);
        return MEM_AW'(full);
    endfunction

    function automatic logic [7:0] ctrl_word(input int mode, input int step, input int dual, input int ap);
        return 8'(mode | (step << 3) | (dual << 5) | (ap << 6));
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input logic wr, input logic exp_hit,
                         input logic [MEM_AW-1:0] exp_a, input string tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        n_chk++;
        if (vm_hit !== exp_hit || (exp_hit && vm_addr !== exp_a)) begin
            n_bad++;
            $display("FAIL %s addr=%h: hit=%b vm_addr=%h expected hit=%b vm_addr=%h",
                     tag, a, vm_hit, vm_addr, exp_hit, exp_a);
        end
    endtask

    task automatic t_reset;
        n_chk++;
        if (vm_hit !== 1'b0 || vm_addr !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: hit=%b addr=%h expected 0/0", vm_hit, vm_addr);
        end
        probe(24'h0A0000, 1'b0, 1'b0, '0, "R1 window off after reset");
    endtask

    task automatic t_graphics;
        cfg_write(2'd0, ctrl_word(1, 0, 0, 0));
        probe(24'h0A1234, 1'b0, 1'b1, 20'h01234, "R2 gfx mid");
        probe(24'h0AFFFF, 1'b0, 1'b1, 20'h0FFFF, "R2 gfx top edge");
        probe(24'h09FFFF, 1'b0, 1'b0, '0, "R2 below gfx");
        probe(24'h0B0000, 1'b0, 1'b0, '0, "R2 above gfx");
    endtask

    task automatic t_text;
        cfg_write(2'd0, ctrl_word(2, 0, 0, 0));
        probe(24'h0B0000, 1'b0, 1'b1, 20'h00000, "R3 mono base");
        probe(24'h0B7FFF, 1'b0, 1'b1, 20'h07FFF, "R3 mono top");
        probe(24'h0B8000, 1'b0, 1'b0, '0, "R3 mono excludes color");
        cfg_write(2'd0, ctrl_word(3, 0, 0, 0));
        probe(24'h0B8000, 1'b0, 1'b1, 20'h00000, "R3 color base");
        probe(24'h0BFFFF, 1'b0, 1'b1, 20'h07FFF, "R3 color top");
        probe(24'h0B7FFF, 1'b0, 1'b0, '0, "R3 color excludes mono");
        probe(24'h0C0000, 1'b0, 1'b0, '0, "R3 above color");
    endtask

    task automatic t_combined;
        cfg_write(2'd0, ctrl_word(4, 0, 0, 0));
        probe(24'h0A0000, 1'b0, 1'b1, 20'h00000, "R4 wide base");
        probe(24'h0BFFFF, 1'b0, 1'b1, 20'h1FFFF, "R4 wide top");
        probe(24'h0B0010, 1'b1, 1'b1, 20'h10010, "R4 wide upper half");
    endtask

    task automatic t_step;
        cfg_write(2'd1, 8'd5);
        for (int s = 0; s < 4; s++) begin
            cfg_write(2'd0, ctrl_word(1, s, 0, 0));
            probe(24'h0A0010, 1'b0, 1'b1, expect_addr(5, s, 'h10), $sformatf("R5 step code %0d", s));
        end
        cfg_write(2'd1, 8'h1F);
        probe(24'h0AFFFF, 1'b0, 1'b1, expect_addr('h1F, 3, 'hFFFF), "R5 top of memory");
        cfg_write(2'd1, 8'h10);
        probe(24'h0A0020, 1'b0, 1'b1, expect_addr('h10, 3, 'h20), "R5 wrap modulo memory");
    endtask

    task automatic t_dual;
        cfg_write(2'd1, 8'd1);
        cfg_write(2'd2, 8'd3);
        cfg_write(2'd0, ctrl_word(1, 3, 1, 0));
        probe(24'h0A0004, 1'b0, 1'b1, 20'h10004, "R6 dual read uses bank A");
        probe(24'h0A0004, 1'b1, 1'b1, 20'h30004, "R6 dual write uses bank B");
        cfg_write(2'd0, ctrl_word(1, 3, 0, 0));
        probe(24'h0A0004, 1'b1, 1'b1, 20'h10004, "R6 single write uses bank A");
    endtask

    task automatic t_aperture;
        cfg_write(2'd3, 8'd3);
        cfg_write(2'd0, ctrl_word(0, 0, 0, 1));
        probe(24'h312345, 1'b0, 1'b1, 20'h12345, "R7 aperture hit");
        probe(24'h3FFFFF, 1'b1, 1'b1, 20'hFFFFF, "R7 aperture top");
        probe(24'h412345, 1'b0, 1'b0, '0, "R7 outside aperture");
        cfg_write(2'd0, ctrl_word(0, 0, 0, 0));
        probe(24'h312345, 1'b0, 1'b0, '0, "R9 aperture disabled");
    endtask

    task automatic t_priority;
        cfg_write(2'd3, 8'd0);
        cfg_write(2'd1, 8'd2);
        cfg_write(2'd0, ctrl_word(1, 3, 0, 1));
        probe(24'h0A0000, 1'b0, 1'b1, 20'h20000, "R8 window over aperture");
        probe(24'h050000, 1'b0, 1'b1, 20'h50000, "R8 aperture outside window");
    endtask

    task automatic t_idle;
        cfg_write(2'd0, ctrl_word(5, 0, 0, 0));
        probe(24'h0A0000, 1'b0, 1'b0, '0, "R9 reserved mode off");
        cfg_write(2'd0, ctrl_word(1, 0, 0, 0));
        @(negedge clk);
        host_valid = 1'b0; host_addr = 24'h0A0000;
        @(negedge clk);
        n_chk++;
        if (vm_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 idle: hit=%b expected 0", vm_hit);
        end
    endtask

    task automatic t_latency;
        cfg_write(2'd1, 8'd0);
        cfg_write(2'd0, ctrl_word(1, 0, 0, 0));
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = 24'h0A0040;
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        n_chk++;
        if (vm_hit !== 1'b1 || vm_addr !== 20'h00040) begin
            n_bad++;
            $display("FAIL R10 same-edge write: hit=%b addr=%h expected 1/00040", vm_hit, vm_addr);
        end
        host_valid = 1'b0;
        probe(24'h0A0040, 1'b0, 1'b1, 20'h01040, "R10 write seen next cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_graphics();
        t_text();
        t_combined();
        t_step();
        t_dual();
        t_aperture();
        t_priority();
        t_idle();
        t_latency();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule